// File: doc/BRIEF.md
# Addressable Latch with Decoder

This block holds eight storage bits that can be written one at a time from a single serial data input, using a 3-bit select to pick the target bit. Two active-low control inputs choose among four modes: single-bit write, hold, 1-of-8 decode, and clear. In decode mode the selected output copies the data input and every other output is driven low. With data held high this turns the block into an active-high one-hot decoder.

The storage is a clocked register, not level-sensitive storage. All inputs are sampled together on the rising clock edge, so a select that changes while writing is disabled cannot disturb the stored bits. A separate synchronous power-on reset zeroes everything. Decode and clear update the register itself, so when the block returns to write or hold it continues from whatever pattern those modes left behind.

Top module: `addr_latch8`

## Requirements
- R1: While `rst_n` is low at a rising edge, all bits of `q` are 0 after that edge, whatever the other inputs are.
- R2: With `clr_n`=1 and `wr_en_n`=0 (write), the selected bit of `q` takes `din` after the edge and every other bit keeps its value.
- R3: With `clr_n`=1 and `wr_en_n`=1 (hold), `q` is unchanged after the edge, whatever `din` and `sel` are.
- R4: With `clr_n`=0 and `wr_en_n`=0 (decode), after the edge the selected bit of `q` equals `din` and every other bit is 0.
- R5: With `clr_n`=0 and `wr_en_n`=1 (clear), every bit of `q` is 0 after the edge, whatever `din` and `sel` are.
- R6: `sel` is binary with `sel[0]` as the least significant bit, so `sel`=0 addresses `q[0]` and `sel`=7 addresses `q[7]`.
- R7: A write issued right after a decode cycle modifies the pattern the decode left in `q`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous power-on reset, active low |
| din | input | 1 | Serial data bit |
| sel | input | 3 | Binary bit select, bit 0 least significant |
| wr_en_n | input | 1 | Enable, active low |
| clr_n | input | 1 | Clear/decode control, active low |
| q | output | 8 | Stored bits, one output per bit |

## Verification
The hardest case to reach from the ports is a mode change that carries state over: a write that lands on a register already shaped by a decode, or a hold cycle taken while `sel` and `din` toggle over a non-trivial pattern. Directed sequences first build a known pattern through single-bit writes. They then decode into it, write on top of the decoded pattern, and hold while sweeping every select and data value. A long deterministic pseudo-random run follows. It mixes all four modes so that mode changes occur from many different stored patterns.

// File: rtl/addr_latch_pkg.sv
// Package: shared mode type and the decode from the two control inputs.
// Assumes both control inputs are active low.
package addr_latch_pkg;

    typedef enum logic [1:0] {
        MODE_WRITE  = 2'd0,
        MODE_HOLD   = 2'd1,
        MODE_DECODE = 2'd2,
        MODE_CLEAR  = 2'd3
    } latch_mode_e;

    // Map (clr_n, wr_en_n) onto an operating mode.
    function automatic latch_mode_e mode_of(input logic clr_n, input logic wr_en_n);
        latch_mode_e m;
        case ({clr_n, wr_en_n})
            2'b10:   m = MODE_WRITE;
            2'b11:   m = MODE_HOLD;
            2'b00:   m = MODE_DECODE;
            default: m = MODE_CLEAR;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/addr_latch_mode.sv
// Mode decoder: turns the two active-low controls into one mode value.
// Assumes inputs are already synchronous to the block clock.
module addr_latch_mode
    import addr_latch_pkg::*;
(
    input  logic        clr_n,
    input  logic        wr_en_n,
    output latch_mode_e mode
);

    // Pure combinational mapping of the control pair.
    always_comb begin
        mode = mode_of(clr_n, wr_en_n);
    end

endmodule

// File: rtl/addr_latch_sel_dec.sv
// Select decoder: one-hot hit vector from a binary select, bit 0 LSB.
// Assumes WIDTH <= 2**ADDR_W; select codes beyond WIDTH-1 hit nothing.
module addr_latch_sel_dec #(
    parameter int WIDTH  = 8,
    parameter int ADDR_W = $clog2(WIDTH)
) (
    input  logic [ADDR_W-1:0] sel,
    output logic [WIDTH-1:0]  hit
);

    for (genvar i = 0; i < WIDTH; i++) begin : g_hit
        // Compare the select against this bit's index.
        assign hit[i] = (sel == ADDR_W'(i));
    end

endmodule

// File: rtl/addr_latch_cell.sv
// Storage cell: one stored bit, updated on the rising edge per mode.
// Assumes hit is high for exactly the addressed cell.
module addr_latch_cell
    import addr_latch_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  latch_mode_e mode,
    input  logic        hit,
    input  logic        din,
    output logic        q_bit
);

    // Per-mode next-state update, with synchronous power-on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_bit <= 1'b0;
        end else begin
            case (mode)
                MODE_WRITE:  if (hit) q_bit <= din;
                MODE_HOLD:   q_bit <= q_bit;
                MODE_DECODE: q_bit <= hit & din;
                default:     q_bit <= 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/addr_latch8.sv
// Top: addressable bit register with write, hold, decode and clear modes.
// Assumes all inputs synchronous to clk; q is the register contents.
module addr_latch8
    import addr_latch_pkg::*;
#(
    parameter int WIDTH  = 8,
    localparam int ADDR_W = $clog2(WIDTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              din,
    input  logic [ADDR_W-1:0] sel,
    input  logic              wr_en_n,
    input  logic              clr_n,
    output logic [WIDTH-1:0]  q
);

    latch_mode_e      mode;
    logic [WIDTH-1:0] hit;

    addr_latch_mode u_mode (
        .clr_n   (clr_n),
        .wr_en_n (wr_en_n),
        .mode    (mode)
    );

    addr_latch_sel_dec #(.WIDTH(WIDTH), .ADDR_W(ADDR_W)) u_dec (
        .sel (sel),
        .hit (hit)
    );

    for (genvar i = 0; i < WIDTH; i++) begin : g_cell
        addr_latch_cell u_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .mode  (mode),
            .hit   (hit[i]),
            .din   (din),
            .q_bit (q[i])
        );
    end

endmodule

// File: rtl/addr_latch8_chk.sv
// Checker: temporal properties of addr_latch8 observed at its ports.
// Assumes attachment through the bind below.
module addr_latch8_chk #(
    parameter int WIDTH  = 8,
    localparam int ADDR_W = $clog2(WIDTH)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              din,
    input logic [ADDR_W-1:0] sel,
    input logic              wr_en_n,
    input logic              clr_n,
    input logic [WIDTH-1:0]  q
);

    a_r2_write_others: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_n && !wr_en_n) |=>
            (((q ^ $past(q)) & ~(WIDTH'(1) << $past(sel))) == '0) && (q[$past(sel)] == $past(din)));

    a_r3_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_n && wr_en_n) |=> $stable(q));

    a_r4_decode_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_n && !wr_en_n) |=>
            ($countones(q) == int'($past(din))) && (q[$past(sel)] == $past(din)));

    a_r5_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_n && wr_en_n) |=> (q == '0));

endmodule

bind addr_latch8 addr_latch8_chk #(.WIDTH(WIDTH)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .din     (din),
    .sel     (sel),
    .wr_en_n (wr_en_n),
    .clr_n   (clr_n),
    .q       (q)
);

// File: tb/sim_addr_latch8.sv
module sim_addr_latch8;
    timeunit 1ns;
    timeprecision 1ps;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       din = 1'b0;
    logic [2:0] sel = '0;
    logic       wr_en_n = 1'b1;
    logic       clr_n = 1'b1;
    logic [7:0] q;

    logic [7:0] exp_q = '0;
    int         n_vec = 0;
    int         n_bad = 0;
    logic [15:0] lfsr = 16'hACE1;

    always #2.5 clk = ~clk;

    addr_latch8 u0 (
        .clk(clk), .rst_n(rst_n), .din(din), .sel(sel),
        .wr_en_n(wr_en_n), .clr_n(clr_n), .q(q)
    );

    // Reference next state from the requirements.
    function automatic logic [7:0] ref_next(logic [7:0] cur, logic r, logic c, logic e,
                                            logic d, logic [2:0] a);
        logic [7:0] n;
        n = cur;
        if (!r)            n = '0;
        else if (c && !e)  n[a] = d;
        else if (c && e)   n = cur;
        else if (!c && !e) n = d ? (8'd1 << a) : 8'd0;
        else               n = '0;
        return n;
    endfunction

    // Apply one cycle starting at a falling edge, compare at the next one.
    task automatic step(logic r, logic c, logic e, logic d, logic [2:0] a, string tag);
        rst_n = r; clr_n = c; wr_en_n = e; din = d; sel = a;
        exp_q = ref_next(exp_q, r, c, e, d, a);
        @(posedge clk);
        @(negedge clk);
        n_vec++;
        if (q !== exp_q) begin
            n_bad++;
            $display("FAIL %s: q=%b expected %b", tag, q, exp_q);
        end
    endtask

    initial begin
        #900000;
        n_bad++;
        $display("FAIL watchdog: run did not finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        step(1'b0, 1'b1, 1'b1, 1'b0, 3'd0, "R1");
        step(1'b0, 1'b1, 1'b1, 1'b0, 3'd0, "R1");
        // R2 / R6: set every bit one at a time, then clear odd ones.
        for (int a = 0; a < 8; a++) step(1'b1, 1'b1, 1'b0, 1'b1, 3'(a), "R2");
        for (int a = 1; a < 8; a += 2) step(1'b1, 1'b1, 1'b0, 1'b0, 3'(a), "R6");
        // R3: hold over every select and data value.
        for (int a = 0; a < 16; a++) step(1'b1, 1'b1, 1'b1, a[3], 3'(a), "R3");
        // R1: reset with a write request present still clears.
        step(1'b0, 1'b1, 1'b0, 1'b1, 3'd2, "R1");
        // R4 / R6: decode every select with both data values.
        for (int a = 0; a < 16; a++) step(1'b1, 1'b0, 1'b0, a[0], 3'(a >> 1), "R4");
        step(1'b1, 1'b0, 1'b0, 1'b1, 3'd7, "R6");
        // R7: write on top of the decoded pattern.
        step(1'b1, 1'b0, 1'b0, 1'b1, 3'd3, "R4");
        step(1'b1, 1'b1, 1'b0, 1'b1, 3'd5, "R7");
        step(1'b1, 1'b1, 1'b1, 1'b0, 3'd0, "R7");
        // R5: clear over several selects and data values.
        for (int a = 0; a < 8; a++) step(1'b1, 1'b0, 1'b1, a[0], 3'(a), "R5");
        // Mixed-mode pseudo-random run.
        for (int i = 0; i < 20000; i++) begin
            logic c, e;
            string t;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            c = (lfsr[1:0] != 2'b00);
            e = lfsr[2];
            t = c ? (e ? "R3" : "R2") : (e ? "R5" : "R4");
            step(1'b1, c, e, lfsr[7], lfsr[6:4], t);
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule